// File: doc/BRIEF.md
# Keyboard Serial Frame Receiver

This block takes the two open-collector lines of a keyboard port, clock and data, both driven by the keyboard, and turns each eleven-bit frame into a byte for the host. Both lines pass through a synchroniser into the system clock domain. A bit is taken from the data line on every falling edge of the keyboard clock. The keyboard clock runs at roughly 10 to 15 kHz, so many system cycles pass between two edges.

Each frame holds a start bit (0), eight data bits sent least significant bit first, a parity bit that makes the count of ones in data plus parity odd, and a stop bit (1). On the eleventh edge the block judges the frame. A good frame loads the byte register and pulses a valid strobe. A bad frame pulses one of two error strobes and leaves the byte register unchanged.

A missed or spurious clock edge would leave the bit counter out of step with the keyboard. To repair this, a watchdog counter discards a partly received frame when no edge arrives for a set number of system cycles. The next edge is then taken as a fresh start bit.

Top module: `kbd_frame_rx`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `byte_o` is 0 and all three strobes are low.
- R2: On the eleventh sampled falling edge of a frame that is good, `byte_vld_o` pulses and `byte_o` carries the eight data bits. The data bit sampled on the second edge lands in `byte_o[0]` and the one sampled on the ninth edge lands in `byte_o[7]`.
- R3: If the start and stop bits are correct but the data bits plus the tenth sampled bit hold an even number of ones, `parity_err_o` pulses and no byte is delivered.
- R4: If the first sampled bit is 1 or the eleventh is 0, `frame_err_o` pulses and no byte is delivered. This holds whatever the parity is, and `parity_err_o` stays low for that frame.
- R5: `byte_o` changes only in a cycle where `byte_vld_o` is high. It keeps the last good byte through frames that fail.
- R6: Inside a frame, if no falling edge is seen for `TIMEOUT_CYC` system cycles, the partial frame is dropped without any strobe. A gap of exactly `TIMEOUT_CYC` cycles between two falling edges is still accepted. A gap of `TIMEOUT_CYC`+1 is not.
- R7: Each strobe is one system cycle wide, and at most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| kbd_clk_i | input | 1 | Keyboard clock line, asynchronous |
| kbd_dat_i | input | 1 | Keyboard data line, asynchronous |
| byte_o | output | 8 | Last good byte received |
| byte_vld_o | output | 1 | One-cycle pulse: `byte_o` was just loaded |
| frame_err_o | output | 1 | One-cycle pulse: the start or stop bit was wrong |
| parity_err_o | output | 1 | One-cycle pulse: odd parity failed |

## Verification
The watchdog expiry and the arrival of a falling edge can fall on the same system cycle. In that case the edge wins and the frame continues. The bench provokes this by stretching one high phase of the keyboard clock. In one frame the gap between two falling edges is exactly `TIMEOUT_CYC` system cycles, and the frame must still deliver its byte. In the next frame the gap is one cycle longer, and the bench expects no strobe at all until a later clean frame is delivered correctly.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  localparam int DATA_W    = 8;
  localparam int FRAME_LEN = DATA_W + 3;
  localparam int BITCNT_W  = $clog2(FRAME_LEN);

  typedef enum logic [1:0] {
    EV_NONE,
    EV_BYTE,
    EV_FRAME_ERR,
    EV_PARITY_ERR
  } rx_event_e;
endpackage

// File: rtl/kbd_link_sync.sv
module kbd_link_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kbd_clk_i,
  input  logic kbd_dat_i,
  output logic fall_o,
  output logic dat_o
);
  localparam int LANES = 2;

  logic [LANES-1:0] raw_w;
  logic [LANES-1:0] sync_w;
  logic [LANES-1:0] prev_w;

  assign raw_w = {kbd_dat_i, kbd_clk_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SYNC_STAGES:0] pipe_q;
    logic [SYNC_STAGES:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[SYNC_STAGES-1:0], raw_w[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= pipe_d;
    end

    assign sync_w[g] = pipe_q[SYNC_STAGES-1];
    assign prev_w[g] = pipe_q[SYNC_STAGES];
  end

  assign fall_o = prev_w[0] & ~sync_w[0];
  assign dat_o  = sync_w[1];

  logic unused_w;
  assign unused_w = prev_w[1];
endmodule

// File: rtl/kbd_idle_timer.sv
module kbd_idle_timer #(
  parameter int TIMEOUT_CYC = 100_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic fall_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign expire_o = busy_i && !fall_i && (cnt_q == LAST);

  always_comb begin
    if (!busy_i || fall_i || expire_o) cnt_d = '0;
    else                               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/kbd_frame_fsm.sv
module kbd_frame_fsm
  import kbd_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              dat_i,
  input  logic              expire_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              frame_err_o,
  output logic              parity_err_o
);
  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(FRAME_LEN - 1);
  localparam int SH_W = FRAME_LEN - 1;

  logic [BITCNT_W-1:0] bit_cnt_q, bit_cnt_d;
  logic [SH_W-1:0]     shift_q, shift_d;
  logic [DATA_W-1:0]   byte_q, byte_d;
  rx_event_e           ev_q, ev_d;

  logic start_ok, stop_ok, par_ok, last_edge;

  assign last_edge = fall_i && (bit_cnt_q == LAST_BIT);
  assign start_ok  = ~shift_q[0];
  assign stop_ok   = dat_i;
  assign par_ok    = ^shift_q[SH_W-1:1];

  always_comb begin
    bit_cnt_d = bit_cnt_q;
    shift_d   = shift_q;
    byte_d    = byte_q;
    ev_d      = EV_NONE;
    if (last_edge) begin
      bit_cnt_d = '0;
      if (!start_ok || !stop_ok) begin
        ev_d = EV_FRAME_ERR;
      end else if (!par_ok) begin
        ev_d = EV_PARITY_ERR;
      end else begin
        ev_d   = EV_BYTE;
        byte_d = shift_q[DATA_W:1];
      end
    end else if (fall_i) begin
      bit_cnt_d = bit_cnt_q + 1'b1;
      shift_d   = {dat_i, shift_q[SH_W-1:1]};
    end else if (expire_i) begin
      bit_cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      shift_q   <= '0;
      byte_q    <= '0;
      ev_q      <= EV_NONE;
    end else begin
      bit_cnt_q <= bit_cnt_d;
      shift_q   <= shift_d;
      byte_q    <= byte_d;
      ev_q      <= ev_d;
    end
  end

  assign busy_o       = (bit_cnt_q != '0);
  assign byte_o       = byte_q;
  assign byte_vld_o   = (ev_q == EV_BYTE);
  assign frame_err_o  = (ev_q == EV_FRAME_ERR);
  assign parity_err_o = (ev_q == EV_PARITY_ERR);

  // a verdict only follows the closing edge of a frame
  assert_strobe_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q != EV_NONE) |-> $past(fall_i && bit_cnt_q == LAST_BIT));

  assert_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q != EV_NONE) |=> (ev_q == EV_NONE));

  assert_byte_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_q != $past(byte_q)) |-> (ev_q == EV_BYTE));

  assert_timeout_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> (bit_cnt_q == '0));
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx #(
  parameter int TIMEOUT_CYC = 100_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kbd_clk_i,
  input  logic       kbd_dat_i,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic       frame_err_o,
  output logic       parity_err_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic fall_w, dat_w, busy_w, expire_w;

  kbd_link_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .kbd_clk_i (kbd_clk_i),
    .kbd_dat_i (kbd_dat_i),
    .fall_o    (fall_w),
    .dat_o     (dat_w)
  );

  kbd_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .busy_i   (busy_w),
    .fall_i   (fall_w),
    .expire_o (expire_w)
  );

  kbd_frame_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .fall_i       (fall_w),
    .dat_i        (dat_w),
    .expire_i     (expire_w),
    .busy_o       (busy_w),
    .byte_o       (byte_o),
    .byte_vld_o   (byte_vld_o),
    .frame_err_o  (frame_err_o),
    .parity_err_o (parity_err_o)
  );
endmodule

// File: tb/kbd_frame_rx_tb.sv
module kbd_frame_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 40;
  localparam int LOW_CYC    = 8;
  localparam int HIGH_CYC   = 8;
  localparam int NVEC       = 9;

  // {stop, start, parity_flip, data}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 8'h1C},
    {1'b1, 1'b0, 1'b0, 8'h00},
    {1'b1, 1'b0, 1'b0, 8'hFF},
    {1'b1, 1'b0, 1'b0, 8'hA5},
    {1'b1, 1'b0, 1'b1, 8'h5A},
    {1'b1, 1'b1, 1'b0, 8'h33},
    {1'b0, 1'b0, 1'b0, 8'h0F},
    {1'b1, 1'b1, 1'b1, 8'h81},
    {1'b1, 1'b0, 1'b0, 8'hF0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kclk = 1'b1;
  logic kdat = 1'b1;
  logic [7:0] byte_o;
  logic byte_vld_o, frame_err_o, parity_err_o;

  int n_chk = 0, n_bad = 0;
  int n_vld = 0, n_ferr = 0, n_perr = 0, n_shape = 0;
  logic vld_prev = 1'b0, ferr_prev = 1'b0, perr_prev = 1'b0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_frame_rx #(.TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .kbd_clk_i(kclk), .kbd_dat_i(kdat),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o),
    .frame_err_o(frame_err_o), .parity_err_o(parity_err_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_vld_o)   n_vld++;
      if (frame_err_o)  n_ferr++;
      if (parity_err_o) n_perr++;
      if ((32'(byte_vld_o) + 32'(frame_err_o) + 32'(parity_err_o)) > 1) n_shape++;
      if ((byte_vld_o && vld_prev) || (frame_err_o && ferr_prev) ||
          (parity_err_o && perr_prev)) n_shape++;
    end
    vld_prev  = byte_vld_o;
    ferr_prev = frame_err_o;
    perr_prev = parity_err_o;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] build(input logic [10:0] v);
    logic [7:0] d;
    logic par;
    d   = v[7:0];
    par = ~(^d) ^ v[8];
    return {v[10], par, d, v[9]};
  endfunction

  task automatic send(input logic [10:0] f, input int nbits,
                      input int gap_bit, input int gap);
    for (int i = 0; i < nbits; i++) begin
      kdat = f[i];
      repeat ((i == gap_bit) ? gap - LOW_CYC : HIGH_CYC) @(negedge clk);
      kclk = 1'b0;
      repeat (LOW_CYC) @(negedge clk);
      kclk = 1'b1;
    end
    kdat = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic expect_counts(input string req, input int v0, input int f0,
                               input int p0, input int dv, input int df,
                               input int dp);
    check(req, n_vld - v0, dv);
    check(req, n_ferr - f0, df);
    check(req, n_perr - p0, dp);
  endtask

  logic [7:0] last_good;

  initial begin
    int v0, f0, p0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(byte_o), 0);
    check("R1", int'({byte_vld_o, frame_err_o, parity_err_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'({byte_o, byte_vld_o, frame_err_o, parity_err_o}), 0);
    repeat (5) @(negedge clk);
    last_good = 8'h00;

    // vector table: R2 good frames, R3 parity, R4 framing, R5 hold
    for (int k = 0; k < NVEC; k++) begin
      logic bad_frame, bad_par;
      v0 = n_vld; f0 = n_ferr; p0 = n_perr;
      send(build(VEC[k]), 11, -1, 0);
      bad_frame = VEC[k][9] || !VEC[k][10];
      bad_par   = VEC[k][8];
      if (bad_frame)    expect_counts("R4", v0, f0, p0, 0, 1, 0);
      else if (bad_par) expect_counts("R3", v0, f0, p0, 0, 0, 1);
      else begin
        expect_counts("R2", v0, f0, p0, 1, 0, 0);
        last_good = VEC[k][7:0];
      end
      check("R5", int'(byte_o), int'(last_good));
    end

    // R6: partial frame abandoned after silence, then a clean frame
    v0 = n_vld; f0 = n_ferr; p0 = n_perr;
    send(build({3'b100, 8'h6B}), 4, -1, 0);
    repeat (TMO + 10) @(negedge clk);
    expect_counts("R6", v0, f0, p0, 0, 0, 0);
    send(build({3'b100, 8'h6B}), 11, -1, 0);
    check("R6", n_vld - v0, 1);
    check("R6", int'(byte_o), 8'h6B);

    // R6: gap of exactly TMO cycles between falling edges still accepted
    v0 = n_vld;
    send(build({3'b100, 8'hC3}), 11, 5, TMO);
    check("R6", n_vld - v0, 1);
    check("R6", int'(byte_o), 8'hC3);

    // R6: gap of TMO+1 drops the frame; tail then times out silently
    v0 = n_vld; f0 = n_ferr; p0 = n_perr;
    send(build({3'b100, 8'h3C}), 11, 5, TMO + 1);
    repeat (TMO + 10) @(negedge clk);
    expect_counts("R6", v0, f0, p0, 0, 0, 0);
    check("R5", int'(byte_o), 8'hC3);
    send(build({3'b100, 8'h96}), 11, -1, 0);
    check("R6", int'(byte_o), 8'h96);

    // R7: strobe shape over the whole run
    check("R7", n_shape, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule